// File: doc/BRIEF.md
# Byte SPI Controller with Queued Transfers

This block moves bytes over a four-wire serial link, MSB first, either as the clock-generating master or as a slave clocked by an external master. The clock idle level is selectable: incoming data is captured on the first clock edge that leaves the idle level, and outgoing data changes on the edge that returns to it. The host writes bytes to send through a write strobe and takes received bytes from the head of a receive queue with a read strobe.

With queue mode on, each direction holds up to eight bytes, and two level-driven interrupt outputs tell the host when the send queue has drained to half depth and when received bytes are waiting. With queue mode off, each direction holds a single byte and per-byte DMA request lines can be used instead. In slave mode a framing control picks whether chip select must be released between bytes or may stay asserted over a burst. In master mode the same control picks whether chip select is pulsed high between bytes or held low over the whole queued burst.

Clearing the enable empties both queues, clears the sticky error flags and returns the serial pins to idle.

Top module: `spi_byte_ctrl`

## Requirements
- R1: After reset, or while `cfg_enable` is 0, `cs_n_o` is 1, `sck_o` equals `cfg_cpol`, all request, interrupt and error outputs are 0, and both queues are empty.
- R2: As master, each byte is sent and received MSB first; input is captured on the edge of `sck_o` leaving the `cfg_cpol` level, output changes on the edge returning to it, and `sck_o` rests at `cfg_cpol` whenever `cs_n_o` is 1.
- R3: As master with `cfg_hold_frame` = 0, `cs_n_o` goes high for at least two clock cycles after every byte; with `cfg_hold_frame` = 1, `cs_n_o` stays low from the first to the last byte of a queued burst.
- R4: As slave with `cfg_hold_frame` = 0, a byte is accepted only after `cs_in_n` falls; clock edges after the eighth in the same low period are ignored until `cs_in_n` rises and falls again.
- R5: As slave with `cfg_hold_frame` = 1, `cs_in_n` may stay low across many bytes; every eight clock cycles close one byte and the next queued send byte is loaded (0x00 when the send queue is empty).
- R6: With `cfg_fifo_en` = 1, each direction holds eight bytes and delivers them in the order they arrived.
- R7: `irq_tx_half` is 1 exactly when `cfg_enable`, `cfg_fifo_en` and `cfg_txhalf_ie` are 1 and the send queue holds four or fewer bytes.
- R8: `irq_rx_ne` is 1 exactly when `cfg_enable`, `cfg_fifo_en` and `cfg_rxne_ie` are 1 and at least one received byte is waiting.
- R9: A host write to a full send queue is discarded and sets `tx_ovf`, which stays 1 until the block is disabled.
- R10: A byte received while the receive queue is full is discarded and sets `rx_ovr`, which stays 1 until the block is disabled.
- R11: `dma_tx_req` is 1 whenever the block is enabled with `cfg_fifo_en` = 0 and `cfg_txdma_en` = 1, regardless of how full the send buffer is, and 0 whenever `cfg_fifo_en` = 1.
- R12: `dma_rx_req` is 1 when the block is enabled with `cfg_fifo_en` = 0, `cfg_rxdma_en` = 1 and a received byte waiting, and falls once the host reads it.
- R13: With `cfg_fifo_en` = 0, each direction holds a single byte, so a second write or a second received byte before the first is consumed counts as overflow or overrun.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_enable | input | 1 | Block enable; 0 flushes the queues and clears the error flags |
| cfg_master | input | 1 | 1 = master, 0 = slave |
| cfg_cpol | input | 1 | Serial clock idle level |
| cfg_hold_frame | input | 1 | 1 = chip select may stay low over many bytes |
| cfg_fifo_en | input | 1 | 1 = eight-byte queues, 0 = single-byte buffers |
| cfg_txdma_en | input | 1 | Send DMA request enable |
| cfg_rxdma_en | input | 1 | Receive DMA request enable |
| cfg_txhalf_ie | input | 1 | Send-queue half-empty interrupt enable |
| cfg_rxne_ie | input | 1 | Receive-queue not-empty interrupt enable |
| tx_wr | input | 1 | Host write strobe for the send queue |
| tx_data | input | 8 | Byte to queue for sending |
| rx_rd | input | 1 | Host read strobe; removes the head received byte |
| rx_data | output | 8 | Head of the receive queue |
| tx_ovf | output | 1 | Sticky send-queue overflow |
| rx_ovr | output | 1 | Sticky receive-queue overrun |
| irq_tx_half | output | 1 | Send queue at half depth or below |
| irq_rx_ne | output | 1 | Received byte waiting |
| dma_tx_req | output | 1 | Send DMA request |
| dma_rx_req | output | 1 | Receive DMA request |
| sck_in | input | 1 | Serial clock from an external master |
| cs_in_n | input | 1 | Chip select from an external master, active low |
| sdi | input | 1 | Serial data in (MISO as master, MOSI as slave) |
| sck_o | output | 1 | Serial clock driven as master |
| cs_n_o | output | 1 | Chip select driven as master, active low |
| sdo | output | 1 | Serial data out (MOSI as master, MISO as slave) |

## Verification
The assertions assume the configuration inputs stay still while a byte is on the wire, and that an external master holds each serial clock phase for several system clocks so the slave synchronisers see every level. The bench changes configuration only with the block disabled or idle, drives the slave side with six-clock phases, and flips from slave to master only after the send queue has been filled, so the master never starts mid-write. Sticky-flag properties take for granted that the enable is what clears the flags, and the bench reaches every clear through that input.

// File: rtl/spi_pkg.sv
`timescale 1ns/1ps
// Shared definitions for the byte SPI controller.
// Assumes byte-wide serial words throughout.
package spi_pkg;
    localparam int BYTE_W = 8;
    typedef logic [BYTE_W-1:0] byte_t;
endpackage

// File: rtl/spi_byte_fifo.sv
`timescale 1ns/1ps
// Byte queue with a run-time capacity switch.
// With single = 1 it reports full at one entry, giving a plain data
// buffer; otherwise it holds DEPTH entries. Writes into a full queue and
// reads from an empty one are dropped. Assumes DEPTH is a power of two.
module spi_byte_fifo
    import spi_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int AW = $clog2(DEPTH),
    localparam int CW = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic          single,
    input  logic          push,
    input  byte_t         wdata,
    input  logic          pop,
    output byte_t         rdata,
    output logic [CW-1:0] count,
    output logic          full,
    output logic          empty
);
    byte_t          mem [DEPTH];
    logic [AW-1:0]  wp, rp;
    logic           do_push, do_pop;

    assign empty   = (count == '0);
    assign full    = single ? !empty : (count == CW'(DEPTH));
    assign do_push = push && !full && !flush;
    assign do_pop  = pop && !empty && !flush;
    assign rdata   = mem[rp];

    // Storage write; contents need no reset since count guards reads.
    always_ff @(posedge clk) begin
        if (do_push) mem[wp] <= wdata;
    end

    // Pointer and level bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wp    <= '0;
            rp    <= '0;
            count <= '0;
        end else begin
            if (do_push) wp <= wp + 1'b1;
            if (do_pop)  rp <= rp + 1'b1;
            count <= count + CW'(do_push) - CW'(do_pop);
        end
    end

    a_r9_full_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (full && push && !pop && !flush) |=> (count == $past(count)));

    a_r6_pop_removes_one: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !empty && !push && !flush) |=> (count == $past(count) - 1'b1));
endmodule

// File: rtl/spi_shift_engine.sv
`timescale 1ns/1ps
// Serial shift engine for master and slave roles.
// Master: generates sck from a DIV-cycle half period and frames bytes with
// cs_n_o. Slave: synchronises sck_in, cs_in_n and sdi with two flops and
// reacts to their edges. Both capture on the edge leaving the idle level,
// shift on the edge returning to it, and close a byte on the eighth return.
// Assumes an external slave clock phase lasts at least three system clocks.
module spi_shift_engine
    import spi_pkg::*;
#(
    parameter int DIV = 2,
    localparam int DCW = $clog2(DIV + 1)
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  en,
    input  logic  master,
    input  logic  cpol,
    input  logic  hold,
    input  logic  sck_in,
    input  logic  cs_in_n,
    input  logic  sdi,
    output logic  sck_o,
    output logic  cs_n_o,
    output logic  sdo,
    input  logic  tx_avail,
    input  byte_t tx_byte,
    output logic  tx_pop,
    output logic  rx_push,
    output byte_t rx_byte
);
    logic [2:0]     sck_s, cs_s;
    logic [1:0]     sdi_s;
    logic           active, phase, smp;
    logic [2:0]     bcnt;
    byte_t          shreg;
    logic [DCW-1:0] div_cnt, gap;
    logic           slave_on, master_on, cs_fall, cs_rise;
    logic           s_lead, s_trail, m_tick, m_lead, m_trail;
    logic           lead, trail, last, reload, m_start, start, sdi_eff;
    byte_t          load_val;

    // Two-flop synchronisers plus one history stage for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sck_s <= '0;
            cs_s  <= '1;
            sdi_s <= '0;
        end else begin
            sck_s <= {sck_s[1:0], sck_in};
            cs_s  <= {cs_s[1:0], cs_in_n};
            sdi_s <= {sdi_s[0], sdi};
        end
    end

    assign slave_on  = en && !master;
    assign master_on = en && master;
    assign cs_fall   = slave_on && cs_s[2] && !cs_s[1];
    assign cs_rise   = cs_s[1] && !cs_s[2];
    assign s_lead    = slave_on && active && !cs_s[1] && (sck_s[2] == cpol) && (sck_s[1] != cpol);
    assign s_trail   = slave_on && active && !cs_s[1] && (sck_s[2] != cpol) && (sck_s[1] == cpol);
    assign m_tick    = (div_cnt == DCW'(DIV - 1));
    assign m_lead    = master_on && active && m_tick && !phase;
    assign m_trail   = master_on && active && m_tick && phase;
    assign lead      = m_lead || s_lead;
    assign trail     = m_trail || s_trail;
    assign last      = trail && (bcnt == 3'd7);
    assign reload    = last && hold && (master ? tx_avail : 1'b1);
    assign m_start   = master_on && !active && tx_avail && (gap == '0);
    assign start     = m_start || cs_fall;
    assign tx_pop    = (start || reload) && tx_avail;
    assign load_val  = tx_avail ? tx_byte : '0;
    assign sdi_eff   = master ? sdi : sdi_s[1];
    assign rx_push   = last;
    assign rx_byte   = {shreg[BYTE_W-2:0], smp};
    assign sdo       = shreg[BYTE_W-1];
    assign cs_n_o    = !(master_on && active);
    assign sck_o     = cpol ^ (master_on && active && phase);

    // Byte framing, bit counting and the shift register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active  <= 1'b0;
            phase   <= 1'b0;
            smp     <= 1'b0;
            bcnt    <= '0;
            shreg   <= '0;
            div_cnt <= '0;
        end else if (!en || (slave_on && cs_rise)) begin
            active <= 1'b0;
            phase  <= 1'b0;
        end else if (start) begin
            active  <= 1'b1;
            phase   <= 1'b0;
            bcnt    <= '0;
            shreg   <= load_val;
            div_cnt <= '0;
        end else if (active) begin
            div_cnt <= m_tick ? '0 : div_cnt + 1'b1;
            if (lead) begin
                smp   <= sdi_eff;
                phase <= 1'b1;
            end
            if (trail) begin
                phase <= 1'b0;
                bcnt  <= bcnt + 1'b1;
                if (reload)    shreg  <= load_val;
                else if (last) active <= 1'b0;
                else           shreg  <= {shreg[BYTE_W-2:0], smp};
            end
        end
    end

    // Master inter-frame gap: keeps chip select high for DIV cycles.
    always_ff @(posedge clk) begin
        if (!rst_n || !en)                gap <= '0;
        else if (last && !reload)         gap <= DCW'(DIV);
        else if (!active && gap != '0)    gap <= gap - 1'b1;
    end

    a_r4_release_idles: assert property (@(posedge clk) disable iff (!rst_n)
        (slave_on && cs_rise) |=> !active);

    a_r3_cs_gap: assert property (@(posedge clk) disable iff (!rst_n)
        (master_on && $rose(cs_n_o)) |=> cs_n_o);

    a_r3_hold_keeps_cs: assert property (@(posedge clk) disable iff (!rst_n)
        (master_on && hold && active && last && tx_avail) |=> !cs_n_o);
endmodule

// File: rtl/spi_byte_ctrl.sv
`timescale 1ns/1ps
// Byte SPI controller top: send and receive queues, shift engine,
// interrupt and DMA request generation, sticky error flags.
// Assumes configuration inputs change only while no byte is in flight.
module spi_byte_ctrl
    import spi_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int DIV   = 2,
    localparam int CW   = $clog2(DEPTH) + 1,
    localparam int HALF = DEPTH / 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cfg_enable,
    input  logic       cfg_master,
    input  logic       cfg_cpol,
    input  logic       cfg_hold_frame,
    input  logic       cfg_fifo_en,
    input  logic       cfg_txdma_en,
    input  logic       cfg_rxdma_en,
    input  logic       cfg_txhalf_ie,
    input  logic       cfg_rxne_ie,
    input  logic       tx_wr,
    input  logic [7:0] tx_data,
    input  logic       rx_rd,
    output logic [7:0] rx_data,
    output logic       tx_ovf,
    output logic       rx_ovr,
    output logic       irq_tx_half,
    output logic       irq_rx_ne,
    output logic       dma_tx_req,
    output logic       dma_rx_req,
    input  logic       sck_in,
    input  logic       cs_in_n,
    input  logic       sdi,
    output logic       sck_o,
    output logic       cs_n_o,
    output logic       sdo
);
    logic          flush, single;
    logic          tx_pop, tx_full, tx_empty, rx_push, rx_full, rx_empty;
    logic [CW-1:0] tx_count, rx_count;
    byte_t         tx_head, rx_byte;

    assign flush  = !cfg_enable;
    assign single = !cfg_fifo_en;

    spi_byte_fifo #(.DEPTH(DEPTH)) u_txq (
        .clk(clk), .rst_n(rst_n), .flush(flush), .single(single),
        .push(tx_wr), .wdata(tx_data), .pop(tx_pop), .rdata(tx_head),
        .count(tx_count), .full(tx_full), .empty(tx_empty)
    );

    spi_byte_fifo #(.DEPTH(DEPTH)) u_rxq (
        .clk(clk), .rst_n(rst_n), .flush(flush), .single(single),
        .push(rx_push), .wdata(rx_byte), .pop(rx_rd), .rdata(rx_data),
        .count(rx_count), .full(rx_full), .empty(rx_empty)
    );

    spi_shift_engine #(.DIV(DIV)) u_eng (
        .clk(clk), .rst_n(rst_n), .en(cfg_enable), .master(cfg_master),
        .cpol(cfg_cpol), .hold(cfg_hold_frame),
        .sck_in(sck_in), .cs_in_n(cs_in_n), .sdi(sdi),
        .sck_o(sck_o), .cs_n_o(cs_n_o), .sdo(sdo),
        .tx_avail(!tx_empty), .tx_byte(tx_head), .tx_pop(tx_pop),
        .rx_push(rx_push), .rx_byte(rx_byte)
    );

    // Sticky error flags, cleared only by disabling the block.
    always_ff @(posedge clk) begin
        if (!rst_n || !cfg_enable) begin
            tx_ovf <= 1'b0;
            rx_ovr <= 1'b0;
        end else begin
            if (tx_wr && tx_full)   tx_ovf <= 1'b1;
            if (rx_push && rx_full) rx_ovr <= 1'b1;
        end
    end

    assign irq_tx_half = cfg_enable && cfg_fifo_en && cfg_txhalf_ie && (tx_count <= CW'(HALF));
    assign irq_rx_ne   = cfg_enable && cfg_fifo_en && cfg_rxne_ie && !rx_empty;
    assign dma_tx_req  = cfg_enable && !cfg_fifo_en && cfg_txdma_en;
    assign dma_rx_req  = cfg_enable && !cfg_fifo_en && cfg_rxdma_en && !rx_empty;

    a_r10_overrun_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_enable && rx_ovr) |=> rx_ovr);

    a_r9_overflow_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_enable && tx_ovf) |=> tx_ovf);

    a_r1_disable_clears: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_enable |=> (!tx_ovf && !rx_ovr && !irq_rx_ne && !dma_rx_req));
endmodule

// File: tb/tb_spi_byte_ctrl.sv
`timescale 1ns/1ps
module tb_spi_byte_ctrl;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_enable = 0, cfg_master = 0, cfg_cpol = 0, cfg_hold_frame = 0;
    logic cfg_fifo_en = 0, cfg_txdma_en = 0, cfg_rxdma_en = 0;
    logic cfg_txhalf_ie = 0, cfg_rxne_ie = 0;
    logic tx_wr = 0, rx_rd = 0;
    logic [7:0] tx_data = 8'h00;
    logic [7:0] rx_data;
    logic tx_ovf, rx_ovr, irq_tx_half, irq_rx_ne, dma_tx_req, dma_rx_req;
    logic sck_in = 0, cs_in_n = 1, sdi = 0;
    logic sck_o, cs_n_o, sdo;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    spi_byte_ctrl #(.DEPTH(8), .DIV(2)) dut (
        .clk(clk), .rst_n(rst_n), .cfg_enable(cfg_enable), .cfg_master(cfg_master),
        .cfg_cpol(cfg_cpol), .cfg_hold_frame(cfg_hold_frame), .cfg_fifo_en(cfg_fifo_en),
        .cfg_txdma_en(cfg_txdma_en), .cfg_rxdma_en(cfg_rxdma_en),
        .cfg_txhalf_ie(cfg_txhalf_ie), .cfg_rxne_ie(cfg_rxne_ie),
        .tx_wr(tx_wr), .tx_data(tx_data), .rx_rd(rx_rd), .rx_data(rx_data),
        .tx_ovf(tx_ovf), .rx_ovr(rx_ovr), .irq_tx_half(irq_tx_half), .irq_rx_ne(irq_rx_ne),
        .dma_tx_req(dma_tx_req), .dma_rx_req(dma_rx_req),
        .sck_in(sck_in), .cs_in_n(cs_in_n), .sdi(sdi),
        .sck_o(sck_o), .cs_n_o(cs_n_o), .sdo(sdo)
    );

    task automatic report();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic clks(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic push_tx(input logic [7:0] b);
        tx_data = b; tx_wr = 1'b1;
        @(negedge clk);
        tx_wr = 1'b0;
    endtask

    task automatic pop_rx(output logic [7:0] b);
        b = rx_data; rx_rd = 1'b1;
        @(negedge clk);
        rx_rd = 1'b0;
    endtask

    task automatic setup(input bit m, input bit cp, input bit hd, input bit fe,
                         input bit te, input bit re, input bit hie, input bit nie);
        cfg_enable = 1'b0;
        @(negedge clk);
        cfg_master = m; cfg_cpol = cp; cfg_hold_frame = hd; cfg_fifo_en = fe;
        cfg_txdma_en = te; cfg_rxdma_en = re; cfg_txhalf_ie = hie; cfg_rxne_ie = nie;
        sck_in = cp; cs_in_n = 1'b1;
        clks(4);
        cfg_enable = 1'b1;
        clks(2);
    endtask

    task automatic set_cs(input logic v);
        cs_in_n = v;
        clks(6);
    endtask

    // One byte clocked into the slave by the bench acting as master.
    task automatic slave_xfer(input logic [7:0] mo, output logic [7:0] mi);
        mi = 8'h00;
        for (int i = 7; i >= 0; i--) begin
            sdi = mo[i];
            clks(4);
            mi = {mi[6:0], sdo};
            sck_in = ~cfg_cpol;
            clks(6);
            sck_in = cfg_cpol;
            clks(6);
        end
    endtask

    // Master burst of n bytes observed by the bench acting as slave.
    task automatic run_master(input int n, input bit hd, input bit cp);
        logic [7:0] tx [8];
        logic [7:0] pat [8];
        logic [7:0] got [8];
        logic [7:0] cap, r;
        int nbyte, bitc, rises, idle_err, guard;
        logic psck, pcs;
        setup(1'b0, cp, hd, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
        for (int k = 0; k < n; k++) begin
            tx[k]  = 8'h3C + 8'(k) * 8'h51;
            pat[k] = 8'hC3 ^ (8'(k) * 8'h1D);
            push_tx(tx[k]);
        end
        sdi = pat[0][7];
        nbyte = 0; bitc = 0; rises = 0; idle_err = 0; guard = 0; cap = 8'h00;
        psck = cp; pcs = 1'b1;
        cfg_master = 1'b1;
        while ((nbyte < n || cs_n_o == 1'b0) && guard < 4000) begin
            @(negedge clk);
            guard++;
            if (cs_n_o && sck_o !== cp) idle_err++;
            if (!pcs && cs_n_o) rises++;
            if (sck_o !== psck) begin
                if (sck_o !== cp) begin
                    cap = {cap[6:0], sdo};
                    bitc++;
                    if (bitc == 8) begin
                        got[nbyte] = cap;
                        nbyte++;
                        bitc = 0;
                    end
                end else if (nbyte < n) begin
                    sdi = pat[nbyte][7-bitc];
                end
            end
            psck = sck_o; pcs = cs_n_o;
        end
        cfg_master = 1'b0;
        chk("R2 master byte count", 32'(nbyte), 32'(n));
        for (int k = 0; k < n; k++) chk("R2 master MSB-first send", {24'h0, got[k]}, {24'h0, tx[k]});
        chk("R2 sck idle level", 32'(idle_err), 32'd0);
        chk("R3 chip-select framing", 32'(rises), hd ? 32'd1 : 32'(n));
        for (int k = 0; k < n; k++) begin
            pop_rx(r);
            chk("R6 master receive order", {24'h0, r}, {24'h0, pat[k]});
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        report();
        $finish;
    end

    initial begin
        logic [7:0] mi, r;
        logic [7:0] sent [9];
        logic [7:0] q [9];
        clks(4);
        rst_n = 1'b1;
        clks(1);
        // R1 reset state
        chk("R1 cs idle", {31'h0, cs_n_o}, 32'd1);
        chk("R1 sck idle", {31'h0, sck_o}, 32'd0);
        chk("R1 outputs quiet", {26'h0, tx_ovf, rx_ovr, irq_tx_half, irq_rx_ne, dma_tx_req, dma_rx_req}, 32'd0);

        // R7 / R9: send-queue level sweep with the slave idle
        setup(1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
        chk("R7 half irq masked", {31'h0, irq_tx_half}, 32'd0);
        cfg_txhalf_ie = 1'b1;
        for (int lvl = 0; lvl <= 8; lvl++) begin
            #0.1;
            chk("R7 half irq at level", {31'h0, irq_tx_half}, (lvl <= 4) ? 32'd1 : 32'd0);
            q[lvl] = 8'h11 * 8'(lvl + 1) ^ 8'h80;
            if (lvl < 8) push_tx(q[lvl]);
        end
        chk("R9 no overflow at eight", {31'h0, tx_ovf}, 32'd0);
        push_tx(8'hEE);
        chk("R9 overflow sticky", {31'h0, tx_ovf}, 32'd1);
        chk("R7 full queue no irq", {31'h0, irq_tx_half}, 32'd0);

        // R5 / R9 / R10: held-frame slave drains the queue, 9th byte overruns
        cfg_rxne_ie = 1'b1;
        set_cs(1'b0);
        for (int k = 0; k < 9; k++) begin
            sent[k] = 8'h5A ^ (8'(k) * 8'h27);
            slave_xfer(sent[k], mi);
            chk("R5 held-frame slave send", {24'h0, mi}, (k < 8) ? {24'h0, q[k]} : 32'h0);
            if (k == 7) chk("R10 no overrun at eight", {31'h0, rx_ovr}, 32'd0);
        end
        set_cs(1'b1);
        chk("R10 overrun sticky", {31'h0, rx_ovr}, 32'd1);
        chk("R8 rx not empty", {31'h0, irq_rx_ne}, 32'd1);
        for (int k = 0; k < 8; k++) begin
            pop_rx(r);
            chk("R6 slave receive order", {24'h0, r}, {24'h0, sent[k]});
        end
        chk("R8 rx drained", {31'h0, irq_rx_ne}, 32'd0);
        cfg_enable = 1'b0;
        clks(1);
        chk("R1 disable clears flags", {30'h0, tx_ovf, rx_ovr}, 32'd0);

        // R4: toggled framing, one byte per chip-select window
        setup(1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1);
        push_tx(8'h96); push_tx(8'h0F);
        set_cs(1'b0); slave_xfer(8'h5A, mi); set_cs(1'b1);
        chk("R4 slave first byte out", {24'h0, mi}, 32'h96);
        set_cs(1'b0); slave_xfer(8'hE1, mi); set_cs(1'b1);
        chk("R4 slave second byte out", {24'h0, mi}, 32'h0F);
        pop_rx(r); chk("R4 slave rx first", {24'h0, r}, 32'h5A);
        pop_rx(r); chk("R4 slave rx second", {24'h0, r}, 32'hE1);
        chk("R8 empty after reads", {31'h0, irq_rx_ne}, 32'd0);

        setup(1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1);
        push_tx(8'hA7);
        set_cs(1'b0); slave_xfer(8'h33, mi); slave_xfer(8'hCC, r); set_cs(1'b1);
        chk("R4 byte out", {24'h0, mi}, 32'hA7);
        pop_rx(r); chk("R4 first byte kept", {24'h0, r}, 32'h33);
        chk("R4 extra clocks ignored", {31'h0, irq_rx_ne}, 32'd0);

        // R2 / R3 / R6: master bursts over both polarities and framings
        run_master(1, 1'b0, 1'b0);
        run_master(3, 1'b0, 1'b1);
        run_master(4, 1'b1, 1'b0);
        run_master(3, 1'b1, 1'b1);

        // R11 / R12 / R13: single-byte buffers with DMA requests
        setup(1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1);
        chk("R11 tx request when enabled", {31'h0, dma_tx_req}, 32'd1);
        chk("R12 no rx request when empty", {31'h0, dma_rx_req}, 32'd0);
        push_tx(8'h71);
        chk("R11 tx request with buffer full", {31'h0, dma_tx_req}, 32'd1);
        push_tx(8'h72);
        chk("R13 single tx buffer overflow", {31'h0, tx_ovf}, 32'd1);
        chk("R7 no queue irq without queue mode", {30'h0, irq_tx_half, irq_rx_ne}, 32'd0);
        cfg_fifo_en = 1'b1;
        #0.1;
        chk("R11 no tx request in queue mode", {31'h0, dma_tx_req}, 32'd0);
        cfg_fifo_en = 1'b0;
        clks(1);
        set_cs(1'b0); slave_xfer(8'h4D, mi); set_cs(1'b1);
        chk("R13 dropped write not sent", {24'h0, mi}, 32'h71);
        chk("R12 rx request raised", {31'h0, dma_rx_req}, 32'd1);
        set_cs(1'b0); slave_xfer(8'h99, mi); set_cs(1'b1);
        chk("R13 single rx buffer overrun", {31'h0, rx_ovr}, 32'd1);
        pop_rx(r);
        chk("R13 first byte kept", {24'h0, r}, 32'h4D);
        chk("R12 rx request cleared", {31'h0, dma_rx_req}, 32'd0);
        cfg_txdma_en = 1'b0;
        #0.1;
        chk("R11 tx request removed", {31'h0, dma_tx_req}, 32'd0);

        report();
        $finish;
    end
endmodule